// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between a word-wide instruction fetch path and the decoder of an instruction set that mixes 16-bit and 32-bit encodings. Fetch words arrive aligned on 4-byte boundaries, each with its address. The block splits every word into two halfwords and keeps them in a small circular buffer. It looks at the leading buffered halfword to decide whether that halfword is a whole short instruction or the opening half of a long one. A long instruction may start at an address that is 2 mod 4, so its two halves can come from two different fetch words. The block holds such an instruction back until the second word has arrived.

Each instruction leaves through a registered valid/ready port. The port carries the instruction bits, the instruction's byte address, a length flag, and the program-counter value that the instruction observes. That value is always the instruction address plus four. A redirect input flushes everything that is buffered and restarts the stream at a new halfword-aligned target. The fetch side and the decode side are decoupled: words are taken whenever there is room, and instructions are released whenever they are complete.

The control is a three-state machine. `S_SYNC` waits for the first fetch word after reset or a redirect. `S_ASSEMBLE` means the output register is empty and the block is waiting for a complete instruction. `S_PRESENT` means the output register holds an instruction. The named transitions are:
- `sync_to_assemble`: the first fetch word is accepted in `S_SYNC`.
- `assemble_to_present`: a complete instruction is loaded into the output register.
- `present_to_present`: the current output is consumed and the next instruction is loaded in the same cycle.
- `present_to_assemble`: the current output is consumed and nothing complete is waiting.
- `any_to_sync`: a redirect arrives in any state.

Top module: `vli_aligner`

## Requirements
- R1: A halfword whose bits [15:11] are 5'b11101, 5'b11110 or 5'b11111 opens a 32-bit instruction, and `out_is_long` is 1 for it. Every other value, including 5'b11100, is a complete 16-bit instruction, and `out_is_long` is 0 for it.
- R2: A 32-bit instruction is emitted with its first halfword in `out_instr[31:16]` and its second halfword in `out_instr[15:0]`. A 16-bit instruction is emitted in `out_instr[15:0]` with `out_instr[31:16]` equal to zero.
- R3: `out_pc` always equals `out_addr + 4`, for both lengths.
- R4: Within a fetch word, `fetch_data[15:0]` is the halfword at the lower address and `fetch_data[31:16]` is the one at `fetch_addr + 2`. Emitted addresses follow program order and advance by 2 after a short instruction and by 4 after a long one.
- R5: A 32-bit instruction whose second halfword lies in a fetch word not yet received is not emitted, and `out_valid` stays low until that word arrives.
- R6: The buffer holds BUF_DEPTH (default 4) halfwords. `fetch_ready` is high only when at least two entries are free. With the output stalled, and a long instruction in every word starting from an aligned target, exactly three fetch words are accepted before `fetch_ready` falls.
- R7: While `out_valid` is high and `out_ready` is low, the output fields hold steady and `out_valid` stays high.
- R8: A redirect takes effect at the next clock edge. It empties the buffer, drops `out_valid`, and discards any fetch word that completes a handshake in the same cycle. The next instruction emitted is the one at the target.
- R9: If the redirect target is 2 mod 4, the lower halfword of the first fetch word accepted after the redirect is dropped, and that word's upper halfword is emitted first, at the target address.
- R10: After reset the buffer is empty and `out_valid` is low until a fetch word has been accepted. That first word is treated as the word at RESET_ADDR, and its lower half is dropped when RESET_ADDR is 2 mod 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch word is offered |
| fetch_ready | output | 1 | Buffer can take a whole fetch word |
| fetch_addr | input | ADDR_W | Word-aligned address of the fetch word |
| fetch_data | input | 32 | Two halfwords, lower address in [15:0] |
| redir_valid | input | 1 | Flush and restart at `redir_target` |
| redir_target | input | ADDR_W | Halfword-aligned restart address |
| out_valid | output | 1 | An instruction is presented |
| out_ready | input | 1 | Decoder takes the instruction |
| out_instr | output | 32 | Instruction bits, packed per R2 |
| out_addr | output | ADDR_W | Byte address of the instruction |
| out_is_long | output | 1 | 1 for a 32-bit instruction |
| out_pc | output | ADDR_W | Program-counter value seen by the instruction |

## Verification
A redirect can land in the same cycle as a fetch handshake and an output handshake. The bench provokes this by raising `redir_valid` while an instruction is presented with `out_ready` high and a stale fetch word is offered with `fetch_valid` high. In the next cycle it checks that `out_valid` is low and `fetch_ready` is high. It then checks that the first instruction emitted afterwards has the target address and the target's bits, not anything from the stale word. Stall and refill also overlap. With `out_ready` toggled while the fetch side streams words, every held output is compared against the previous cycle's values.

// File: rtl/vla_pkg.sv
package vla_pkg;
    localparam int HW_W    = 16;
    localparam int INSTR_W = 32;

    typedef enum logic [1:0] {
        S_SYNC     = 2'd0,
        S_ASSEMBLE = 2'd1,
        S_PRESENT  = 2'd2
    } vla_state_e;
endpackage

// File: rtl/vla_lenclass.sv
module vla_lenclass
    import vla_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic [LANES*HW_W-1:0] hw_in,
    output logic [LANES-1:0]      long_lead
);
    // Leading five bits 111xx with xx != 00 open a two-halfword instruction.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [4:0] top5;
        assign top5         = hw_in[g*HW_W+11 +: 5];
        assign long_lead[g] = (top5[4:2] == 3'b111) && (top5[1:0] != 2'b00);
    end
endmodule

// File: rtl/vla_hwbuf.sv
module vla_hwbuf
    import vla_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [1:0]      push_cnt,
    input  logic [HW_W-1:0] push_first,
    input  logic [HW_W-1:0] push_second,
    input  logic [1:0]      pop_cnt,
    output logic [HW_W-1:0] head0,
    output logic [HW_W-1:0] head1,
    output logic [CW-1:0]   count
);
    logic [HW_W-1:0] ent_q [DEPTH];
    logic [PW-1:0]   rd_q, wr_q;
    logic [PW-1:0]   rd1, wr1;
    logic [CW-1:0]   cnt_q;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign rd1   = step_ptr(rd_q);
    assign wr1   = step_ptr(wr_q);
    assign head0 = ent_q[rd_q];
    assign head1 = ent_q[rd1];
    assign count = cnt_q;

    // Entry storage: the first pushed halfword lands at the write pointer,
    // the second one just after it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (!clear) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push_cnt != 2'd0 && wr_q == PW'(i))
                    ent_q[i] <= push_first;
                else if (push_cnt == 2'd2 && wr1 == PW'(i))
                    ent_q[i] <= push_second;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_cnt == 2'd1)      wr_q <= wr1;
            else if (push_cnt == 2'd2) wr_q <= step_ptr(wr1);
            if (pop_cnt == 2'd1)       rd_q <= rd1;
            else if (pop_cnt == 2'd2)  rd_q <= step_ptr(rd1);
            cnt_q <= cnt_q + CW'(push_cnt) - CW'(pop_cnt);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (int'(cnt_q) + int'(push_cnt) - int'(pop_cnt)) <= DEPTH);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> int'(pop_cnt) <= int'(cnt_q));
endmodule

// File: rtl/vla_ctrl.sv
module vla_ctrl
    import vla_pkg::*;
#(
    parameter  int                ADDR_W     = 32,
    parameter  int                DEPTH      = 4,
    parameter  logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int                CW         = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    output logic               fetch_ready,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic [31:0]        fetch_data,
    input  logic               redir_valid,
    input  logic [ADDR_W-1:0]  redir_target,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_instr,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_is_long,
    output logic [ADDR_W-1:0]  out_pc,
    input  logic [CW-1:0]      buf_count,
    input  logic [HW_W-1:0]    head0,
    input  logic [HW_W-1:0]    head1,
    input  logic               head_long,
    output logic               buf_clear,
    output logic [1:0]         push_cnt,
    output logic [HW_W-1:0]    push_first,
    output logic [HW_W-1:0]    push_second,
    output logic [1:0]         pop_cnt
);
    vla_state_e        state_q, state_d;
    logic              drop_lo_q;
    logic [ADDR_W-1:0] head_addr_q;
    logic              fetch_go, complete, out_free, load;

    assign fetch_ready = (buf_count <= CW'(DEPTH - 2));
    assign fetch_go    = fetch_valid && fetch_ready;
    assign complete    = head_long ? (buf_count >= CW'(2)) : (buf_count != '0);
    assign out_free    = (state_q != S_PRESENT) || out_ready;
    assign load        = !redir_valid && (state_q != S_SYNC) && complete && out_free;
    assign out_valid   = (state_q == S_PRESENT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (redir_valid) begin
            state_d = S_SYNC;                              // any_to_sync
        end else begin
            unique case (state_q)
                S_SYNC:     if (fetch_go) state_d = S_ASSEMBLE;           // sync_to_assemble
                S_ASSEMBLE: if (load)     state_d = S_PRESENT;            // assemble_to_present
                S_PRESENT:  if (!load && out_ready) state_d = S_ASSEMBLE; // present_to_assemble
                default:    state_d = S_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_SYNC;
        else        state_q <= state_d;
    end

    // Buffer control
    always_comb begin
        buf_clear   = redir_valid;
        push_cnt    = 2'd0;
        push_first  = fetch_data[15:0];
        push_second = fetch_data[31:16];
        if (!redir_valid && fetch_go) begin
            if (state_q == S_SYNC && drop_lo_q) begin
                push_cnt   = 2'd1;
                push_first = fetch_data[31:16];
            end else begin
                push_cnt = 2'd2;
            end
        end
        pop_cnt = load ? (head_long ? 2'd2 : 2'd1) : 2'd0;
    end

    // Output register and instruction address tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_lo_q   <= RESET_ADDR[1];
            head_addr_q <= RESET_ADDR;
            out_instr   <= '0;
            out_addr    <= '0;
            out_is_long <= 1'b0;
            out_pc      <= '0;
        end else if (redir_valid) begin
            drop_lo_q   <= redir_target[1];
            head_addr_q <= redir_target;
        end else begin
            if (state_q == S_SYNC && fetch_go)
                head_addr_q <= {fetch_addr[ADDR_W-1:2], drop_lo_q, 1'b0};
            if (load) begin
                out_instr   <= head_long ? {head0, head1} : {{HW_W{1'b0}}, head0};
                out_addr    <= head_addr_q;
                out_is_long <= head_long;
                out_pc      <= head_addr_q + ADDR_W'(4);
                head_addr_q <= head_addr_q + (head_long ? ADDR_W'(4) : ADDR_W'(2));
            end
        end
    end

    assert_long_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_is_long |-> out_instr[31:29] == 3'b111 && out_instr[28:27] != 2'b00);

    assert_short_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_is_long |-> !(out_instr[15:13] == 3'b111 && out_instr[12:11] != 2'b00));

    assert_short_pack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_is_long |-> out_instr[31:16] == '0);

    assert_pc_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_pc == out_addr + ADDR_W'(4));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !redir_valid |=>
            !out_valid || out_addr == $past(out_addr) + ($past(out_is_long) ? ADDR_W'(4) : ADDR_W'(2)));

    assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> fetch_addr[1:0] == 2'b00);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !redir_valid |=>
            out_valid && $stable(out_instr) && $stable(out_addr) && $stable(out_is_long));

    assert_redirect_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !out_valid && buf_count == '0);

    assert_target_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !redir_target[0]);
endmodule

// File: rtl/vli_aligner.sv
module vli_aligner
    import vla_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                BUF_DEPTH  = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(32'h0000_4000)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    output logic               fetch_ready,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic [31:0]        fetch_data,
    input  logic               redir_valid,
    input  logic [ADDR_W-1:0]  redir_target,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_instr,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_is_long,
    output logic [ADDR_W-1:0]  out_pc
);
    localparam int CW = $clog2(BUF_DEPTH + 1);

    logic [CW-1:0]   buf_count;
    logic [HW_W-1:0] head0, head1, push_first, push_second;
    logic            head_long, buf_clear;
    logic [1:0]      push_cnt, pop_cnt;

    vla_hwbuf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (buf_clear),
        .push_cnt   (push_cnt),
        .push_first (push_first),
        .push_second(push_second),
        .pop_cnt    (pop_cnt),
        .head0      (head0),
        .head1      (head1),
        .count      (buf_count)
    );

    vla_lenclass #(.LANES(1)) u_cls (
        .hw_in    (head0),
        .long_lead(head_long)
    );

    vla_ctrl #(
        .ADDR_W    (ADDR_W),
        .DEPTH     (BUF_DEPTH),
        .RESET_ADDR(RESET_ADDR)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_ready (fetch_ready),
        .fetch_addr  (fetch_addr),
        .fetch_data  (fetch_data),
        .redir_valid (redir_valid),
        .redir_target(redir_target),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_instr   (out_instr),
        .out_addr    (out_addr),
        .out_is_long (out_is_long),
        .out_pc      (out_pc),
        .buf_count   (buf_count),
        .head0       (head0),
        .head1       (head1),
        .head_long   (head_long),
        .buf_clear   (buf_clear),
        .push_cnt    (push_cnt),
        .push_first  (push_first),
        .push_second (push_second),
        .pop_cnt     (pop_cnt)
    );
endmodule

// File: tb/sim_vli_aligner.sv
`timescale 1ns/1ps
module sim_vli_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        fetch_ready;
    logic [31:0] fetch_addr = '0;
    logic [31:0] fetch_data = '0;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_target = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_instr, out_addr, out_pc;
    logic        out_is_long;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    vli_aligner u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .redir_valid(redir_valid), .redir_target(redir_target),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_instr(out_instr), .out_addr(out_addr),
        .out_is_long(out_is_long), .out_pc(out_pc)
    );

    // Fetch words starting at 0x4000; lower address in [15:0].
    localparam int N_FW = 5;
    localparam logic [31:0] FW [N_FW] = '{
        32'hF000_2101, 32'hBF00_B802, 32'hE8BD_4408, 32'hE7FE_8FF0, 32'h1234_FFFF
    };
    // Expected outputs: {address, instruction, long flag}.
    localparam int N_EX = 7;
    localparam logic [64:0] EX [N_EX] = '{
        {32'h4000, 32'h0000_2101, 1'b0},
        {32'h4002, 32'hF000_B802, 1'b1},
        {32'h4006, 32'h0000_BF00, 1'b0},
        {32'h4008, 32'h0000_4408, 1'b0},
        {32'h400A, 32'hE8BD_8FF0, 1'b1},
        {32'h400E, 32'h0000_E7FE, 1'b0},
        {32'h4010, 32'hFFFF_1234, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic redirect(input logic [31:0] t);
        redir_valid  = 1'b1;
        redir_target = t;
        step();
        redir_valid  = 1'b0;
    endtask

    task automatic feed(input logic [31:0] a, input logic [31:0] d);
        int w = 0;
        fetch_valid = 1'b1;
        fetch_addr  = a;
        fetch_data  = d;
        while (!fetch_ready && w < 50) begin step(); w++; end
        step();
        fetch_valid = 1'b0;
    endtask

    task automatic take_out(input string req, input logic [31:0] ea,
                            input logic [31:0] ei, input logic el);
        int w = 0;
        out_ready = 1'b1;
        while (!out_valid && w < 20) begin step(); w++; end
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " addr"},  64'(out_addr), 64'(ea));
        chk({req, " instr"}, 64'(out_instr), 64'(ei));
        chk({req, " long"},  64'(out_is_long), 64'(el));
        chk("R3 pc",         64'(out_pc), 64'(ea + 32'd4));
        step();
        out_ready = 1'b0;
    endtask

    // Walk the vector table; mode 1 stalls the output every third cycle.
    task automatic run_table(input int mode);
        int fi = 0, oi = 0, cyc = 0;
        logic held = 1'b0;
        logic [31:0] held_i = '0, held_a = '0;
        while (oi < N_EX && cyc < 300) begin
            if (held) begin
                chk("R7 held valid", 64'(out_valid), 64'd1);
                chk("R7 held instr", 64'(out_instr), 64'(held_i));
                chk("R7 held addr",  64'(out_addr), 64'(held_a));
            end
            fetch_valid = (fi < N_FW);
            fetch_addr  = 32'h4000 + 32'(fi) * 32'd4;
            fetch_data  = (fi < N_FW) ? FW[fi] : 32'h0;
            out_ready   = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            if (out_valid && out_ready) begin
                chk("R4 addr",        64'(out_addr), 64'(EX[oi][64:33]));
                chk("R1 R2 instr",    64'(out_instr), 64'(EX[oi][32:1]));
                chk("R1 long flag",   64'(out_is_long), 64'(EX[oi][0]));
                chk("R3 pc",          64'(out_pc), 64'(EX[oi][64:33] + 32'd4));
                oi++;
            end
            held   = out_valid && !out_ready;
            held_i = out_instr;
            held_a = out_addr;
            if (fetch_valid && fetch_ready) fi++;
            step();
            cyc++;
        end
        chk("R4 all emitted", 64'(oi), 64'(N_EX));
        fetch_valid = 1'b0;
        out_ready   = 1'b0;
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        step();
        chk("R6 ready after reset", 64'(fetch_ready), 64'd1);
        for (int i = 0; i < 4; i++) step();
        chk("R10 idle without fetch", 64'(out_valid), 64'd0);

        // Table stream straight from reset, then with output stalls.
        run_table(0);
        redirect(32'h4000);
        run_table(1);

        // R5: long instruction split across two words waits for the second word.
        begin
            int hs = 0;
            redirect(32'h4000);
            feed(32'h4000, FW[0]);
            out_ready = 1'b1;
            for (int i = 0; i < 6; i++) begin
                if (out_valid) begin
                    hs++;
                    chk("R5 short before split", 64'(out_instr), 64'h2101);
                end
                step();
            end
            out_ready = 1'b0;
            chk("R5 one output only", 64'(hs), 64'd1);
            chk("R5 waits for tail", 64'(out_valid), 64'd0);
            feed(32'h4004, FW[1]);
            take_out("R5 split long", 32'h4002, 32'hF000_B802, 1'b1);
        end

        // R6: stalled output with a long instruction in every word.
        begin
            int acc = 0;
            redirect(32'h8000);
            out_ready = 1'b0;
            for (int i = 0; i < 8; i++) begin
                fetch_valid = 1'b1;
                fetch_addr  = 32'h8000 + 32'(acc) * 32'd4;
                fetch_data  = 32'h1234_F000;
                if (fetch_ready) acc++;
                step();
            end
            fetch_valid = 1'b0;
            chk("R6 words accepted", 64'(acc), 64'd3);
            chk("R6 ready low when full", 64'(fetch_ready), 64'd0);
            take_out("R6 drain 0", 32'h8000, 32'hF000_1234, 1'b1);
            take_out("R6 drain 1", 32'h8004, 32'hF000_1234, 1'b1);
            take_out("R6 drain 2", 32'h8008, 32'hF000_1234, 1'b1);
        end

        // R8: redirect, fetch handshake and output handshake in one cycle.
        begin
            int w = 0;
            redirect(32'h4000);
            feed(32'h4000, FW[0]);
            while (!out_valid && w < 10) begin step(); w++; end
            redir_valid  = 1'b1;
            redir_target = 32'h6000;
            fetch_valid  = 1'b1;
            fetch_addr   = 32'h4004;
            fetch_data   = 32'hBF00_B802;
            out_ready    = 1'b1;
            step();
            redir_valid = 1'b0;
            fetch_valid = 1'b0;
            out_ready   = 1'b0;
            chk("R8 valid dropped", 64'(out_valid), 64'd0);
            chk("R8 buffer emptied", 64'(fetch_ready), 64'd1);
            feed(32'h6000, 32'hBF00_4408);
            take_out("R8 first at target", 32'h6000, 32'h0000_4408, 1'b0);
            take_out("R8 second at target", 32'h6002, 32'h0000_BF00, 1'b0);
        end

        // R9: odd-halfword target drops the lower half of the first word.
        redirect(32'h5002);
        feed(32'h5000, 32'hBF00_2222);
        take_out("R9 upper half first", 32'h5002, 32'h0000_BF00, 1'b0);
        out_ready = 1'b1;
        for (int i = 0; i < 4; i++) step();
        chk("R9 lower half dropped", 64'(out_valid), 64'd0);
        out_ready = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule